// File: doc/BRIEF.md
# Majority-Only In-Memory Processor Core

This core runs programs built from a single instruction. The instruction takes three inputs, A, B and C, and computes the bitwise majority of A, the complement of B, and C. C is always the current contents of a destination word in memory, and the result replaces that word in place. Clearing a word, copying it with inversion and forming an AND are all written as short sequences of this one instruction. The program and its data share one word-addressed memory inside the core, and every operand is fetched from that memory.

Each instruction takes two words. The first word holds a flag byte in bits 15:8 and the destination address in bits 7:0. Flag bit 0 (word bit 8) marks A as a literal. Flag bit 1 (word bit 9) marks B as a literal. Flag bit 2 (word bit 10) means halt. The second word holds the A field in bits 15:8 and the B field in bits 7:0. A literal takes bit 0 of its field and copies it to every bit of the word, so it is either all zeros or all ones. A field without the literal flag is a memory address.

While reset is held, a load port writes words into the memory. When reset is released the core starts at address 0. Every write the core makes is reported one cycle later on a registered write-report port.

Top module: `majc_core`

## Requirements
- R1: While reset is high and in the cycles that follow it before the first write completes, `done` is 0, `pc` is 0 and `wr_valid` is 0.
- R2: Each written word equals (A & ~B) | (A & C) | (~B & C), computed bit by bit, where C is the old contents of the destination.
- R3: When flag bit 0 (word-0 bit 8) or flag bit 1 (word-0 bit 9) is set, operand A or operand B is bit 0 of its field copied to all 16 bits, and no memory value is used for that operand.
- R4: The result overwrites the destination address. A later instruction that reads that address gets the new value.
- R5: Each instruction takes exactly six cycles, and `pc` advances by 2 after each write. The k-th write (counting from 1) shows on `wr_valid`/`wr_addr`/`wr_data` at the 6k-th rising edge after reset is released.
- R6: An instruction with flag bit 2 (word-0 bit 10) set raises `done` at the second rising edge after that instruction's fetch begins. After that `done` stays high, `pc` stays on the halting instruction's address and no further writes occur.
- R7: The four-instruction sequence RM(#0,#1,C), RM(#0,#1,T), RM(#1,B,T), RM(A,T,C) leaves C equal to A AND B.
- R8: While reset is high, the load port (`ld_we`, `ld_addr`, `ld_data`) writes the memory, and the core writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; when high, the load port owns the memory |
| ld_we | input | 1 | Load-port write enable (acted on only during reset) |
| ld_addr | input | 8 | Load-port word address |
| ld_data | input | 16 | Load-port write data |
| done | output | 1 | Registered halt status |
| pc | output | 8 | Program counter (address of word 0 of the current instruction) |
| wr_valid | output | 1 | Registered pulse: the core wrote memory in the previous cycle |
| wr_addr | output | 8 | Address of the reported write |
| wr_data | output | 16 | Data of the reported write |

## Verification
The instructions are long enough that every internal slip appears on the write-report port within one instruction. If the sequencer state is wrong, the write pulse moves off its six-cycle slot. If a latched operand is wrong, or a literal is expanded wrongly, that instruction's `wr_data` is wrong. If the program counter or the decoded destination is wrong, `wr_addr` is wrong within the next six cycles. A broken halt path shows on `done` two cycles after the halting fetch begins, or as a stray write in the silent window that follows.

// File: rtl/majc_pkg.sv
package majc_pkg;

  typedef enum logic [2:0] {
    ST_FETCH0 = 3'd0,
    ST_FETCH1 = 3'd1,
    ST_READ_A = 3'd2,
    ST_READ_B = 3'd3,
    ST_READ_C = 3'd4,
    ST_WRITE  = 3'd5,
    ST_HALT   = 3'd6
  } seq_state_t;

  localparam int FLG_LIT_A = 0;
  localparam int FLG_LIT_B = 1;
  localparam int FLG_STOP  = 2;

endpackage

// File: rtl/majc_mem.sv
module majc_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/majc_alu.sv
module majc_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] r
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic nb;
    assign nb   = ~b[i];
    assign r[i] = (a[i] & nb) | (a[i] & c[i]) | (nb & c[i]);
  end

  // R2: wherever A and C agree, the majority must follow them regardless of B
  always_comb begin
    a_r2_agree_wins: assert ((~(a ^ c) & (r ^ a)) == '0);
  end
endmodule

// File: rtl/majc_seq.sv
module majc_seq
  import majc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic          done,
  output logic [AW-1:0] pc
);
  localparam int FA_LO = DW - AW;
  localparam int FB_LO = 0;
  localparam int FL_LO = AW;

  seq_state_t    state;
  logic [DW-1:0] w0;
  logic [DW-1:0] w1;

  logic [AW-1:0] fld_a;
  logic [AW-1:0] fld_b;
  logic [AW-1:0] dst;
  logic          lit_a;
  logic          lit_b;

  assign fld_a = w1[FA_LO +: AW];
  assign fld_b = w1[FB_LO +: AW];
  assign dst   = w0[0 +: AW];
  assign lit_a = w0[FL_LO + FLG_LIT_A];
  assign lit_b = w0[FL_LO + FLG_LIT_B];

  always_comb begin
    case (state)
      ST_FETCH0: mem_addr = pc;
      ST_FETCH1: mem_addr = pc + AW'(1);
      ST_READ_A: mem_addr = rdata[FA_LO +: AW];
      ST_READ_B: mem_addr = fld_b;
      ST_READ_C: mem_addr = dst;
      ST_WRITE:  mem_addr = dst;
      default:   mem_addr = pc;
    endcase
  end

  assign mem_we = (state == ST_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH0;
      pc    <= '0;
      w0    <= '0;
      w1    <= '0;
      op_a  <= '0;
      op_b  <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_FETCH0: state <= ST_FETCH1;
        ST_FETCH1: begin
          w0 <= rdata;
          if (rdata[FL_LO + FLG_STOP]) begin
            state <= ST_HALT;
            done  <= 1'b1;
          end else begin
            state <= ST_READ_A;
          end
        end
        ST_READ_A: begin
          w1    <= rdata;
          state <= ST_READ_B;
        end
        ST_READ_B: begin
          op_a  <= lit_a ? {DW{fld_a[0]}} : rdata;
          state <= ST_READ_C;
        end
        ST_READ_C: begin
          op_b  <= lit_b ? {DW{fld_b[0]}} : rdata;
          state <= ST_WRITE;
        end
        ST_WRITE: begin
          pc    <= pc + AW'(2);
          state <= ST_FETCH0;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  // R6: a halted core never writes
  a_r6_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);

  // R6: halt is sticky and freezes the program counter
  a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(pc)));

  // R5: each write step moves the program counter on by two words
  a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (pc == $past(pc) + AW'(2)));

  // R5: a write is followed by a new fetch
  a_r5_write_then_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (state == ST_FETCH0));
endmodule

// File: rtl/majc_core.sv
module majc_core #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [7:0]    ld_addr,
  input  logic [15:0]   ld_data,
  output logic          done,
  output logic [7:0]    pc,
  output logic          wr_valid,
  output logic [7:0]    wr_addr,
  output logic [15:0]   wr_data
);
  logic [AW-1:0] seq_addr;
  logic          seq_we;
  logic [DW-1:0] op_a;
  logic [DW-1:0] op_b;
  logic [DW-1:0] rdata;
  logic [DW-1:0] result;
  logic [AW-1:0] pc_int;
  logic          done_int;

  logic          m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;

  majc_seq #(.DW(DW), .AW(AW)) seq_i (
    .clk(clk), .rst(rst), .rdata(rdata),
    .mem_addr(seq_addr), .mem_we(seq_we),
    .op_a(op_a), .op_b(op_b), .done(done_int), .pc(pc_int)
  );

  majc_alu #(.DW(DW)) alu_i (
    .a(op_a), .b(op_b), .c(rdata), .r(result)
  );

  assign m_we    = rst ? ld_we            : seq_we;
  assign m_addr  = rst ? AW'(ld_addr)     : seq_addr;
  assign m_wdata = rst ? DW'(ld_data)     : result;

  majc_mem #(.DW(DW), .AW(AW)) mem_i (
    .clk(clk), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= seq_we;
      wr_addr  <= 8'(seq_addr);
      wr_data  <= 16'(result);
    end
  end

  assign done = done_int;
  assign pc   = 8'(pc_int);

  // R8: the core reports no write in the cycle after a reset cycle
  a_r8_reset_no_write: assert property (@(posedge clk)
    rst |=> !wr_valid);

  // R5: report pulses are single cycles, six cycles apart
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
endmodule

// File: tb/majc_core_tb_top.sv
module majc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        done;
  logic [7:0]  pc;
  logic        wr_valid;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  always #5 clk = ~clk;

  majc_core dut_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .done(done), .pc(pc), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct {
    int          cyc;
    logic [7:0]  addr;
    logic [15:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] model [256];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          running = 1'b0;
  int          n_instr = 0;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] maj_inv(logic [15:0] a, logic [15:0] b, logic [15:0] c);
    return (a & ~b) | (a & c) | (~b & c);
  endfunction

  task automatic put_instr(input bit la, input bit lb, input logic [7:0] fa,
                           input logic [7:0] fb, input logic [7:0] d);
    model[2*n_instr]     = {5'b0, 1'b0, lb, la, d};
    model[2*n_instr + 1] = {fa, fb};
    n_instr++;
  endtask

  // driver: runs the reference model and pushes each expected write
  task automatic predict(input string tags[]);
    for (int k = 0; k < n_instr; k++) begin
      logic [15:0] w0, w1, a, b, r;
      exp_t e;
      w0 = model[2*k];
      w1 = model[2*k + 1];
      a  = w0[8] ? {16{w1[8]}} : model[w1[15:8]];
      b  = w0[9] ? {16{w1[0]}} : model[w1[7:0]];
      r  = maj_inv(a, b, model[w0[7:0]]);
      model[w0[7:0]] = r;
      e.cyc = 6 * (k + 1); e.addr = w0[7:0]; e.data = r; e.tag = tags[k];
      sb.push_back(e);
    end
  endtask

  // monitor: compares each reported write against the scoreboard
  always @(negedge clk) begin
    if (running && wr_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6", "unexpected write", int'(wr_addr), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.cyc, "R5", "write cycle", cyc, e.cyc);
        check(wr_addr == e.addr, e.tag, "write addr", int'(wr_addr), int'(e.addr));
        check(wr_data == e.data, e.tag, "write data", int'(wr_data), int'(e.data));
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    string tags[];
    logic [15:0] img [256];
    for (int i = 0; i < 256; i++) model[i] = 16'h0;

    model[8'h80] = 16'hF0F0;  // A
    model[8'h81] = 16'hFF00;  // B
    model[8'h82] = 16'h1234;  // C old
    model[8'h83] = 16'hABCD;  // T old
    model[8'h84] = 16'h5A3C;
    model[8'h85] = 16'h0FF0;
    model[8'h86] = 16'h9669;
    model[8'h87] = 16'h0001;
    model[8'h88] = 16'hC3C3;

    put_instr(1, 1, 8'h00, 8'h01, 8'h82);  // C = 0
    put_instr(1, 1, 8'h00, 8'h01, 8'h83);  // T = 0
    put_instr(1, 0, 8'h01, 8'h81, 8'h83);  // T = ~B
    put_instr(0, 0, 8'h80, 8'h83, 8'h82);  // C = A & B
    put_instr(0, 0, 8'h84, 8'h85, 8'h86);  // all memory operands
    put_instr(1, 1, 8'h01, 8'h00, 8'h87);  // ones
    put_instr(0, 1, 8'h80, 8'h00, 8'h86);  // chained destination
    put_instr(1, 0, 8'h00, 8'h84, 8'h88);  // ~B & C
    model[2*n_instr]     = 16'h0400;       // halt
    model[2*n_instr + 1] = 16'h0000;

    for (int i = 0; i < 256; i++) img[i] = model[i];
    tags = '{"R2", "R2", "R3", "R7", "R8", "R3", "R4", "R2"};
    predict(tags);

    // R7: the AND sequence must give A & B directly
    check(sb[3].data == (16'hF0F0 & 16'hFF00), "R7", "model and", int'(sb[3].data), 16'hF000);

    // R8: preload through the load port during reset
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      if (i < 2*n_instr + 2 || (i >= 8'h80 && i <= 8'h88)) begin
        ld_we = 1'b1; ld_addr = 8'(i); ld_data = img[i];
        @(negedge clk);
      end
    end
    ld_we = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(pc == 8'h00, "R1", "pc in reset", int'(pc), 0);
    check(wr_valid == 1'b0, "R1", "wr_valid in reset", int'(wr_valid), 0);

    running = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    check(wr_valid == 1'b0 && done == 1'b0 && pc == 8'h00, "R1", "state after release",
          int'({wr_valid, done, pc}), 0);

    while (cyc < 6 * n_instr + 1) @(negedge clk);
    check(done == 1'b0, "R6", "done before halt fetch done", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R6", "done raised", int'(done), 1);
    check(pc == 8'(2 * n_instr), "R6", "pc at halt", int'(pc), 2 * n_instr);
    check(sb.size() == 0, "R5", "writes outstanding", sb.size(), 0);

    repeat (40) @(negedge clk);
    check(done == 1'b1, "R6", "done sticky", int'(done), 1);
    check(pc == 8'(2 * n_instr), "R6", "pc frozen", int'(pc), 2 * n_instr);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule